// File: doc/BRIEF.md
# Power-Mode and Reset Controller

This block keeps track of which power state a serial converter core is in: fully on, partly powered down, fully powered down, or coming back up. It watches each completed serial frame (signalled by a chip-select rising-edge pulse, a flag saying the frame had its full sixteen clocks, and the write-enable and power-down bits carried by that frame). It also watches one asynchronous active-low pin that acts either as a register reset or as a full power-down request, depending on how long it stays low.

From these inputs it drives the state code, a gate for control-register writes, a flag saying the frame now starting carries a valid conversion result, and one-cycle pulses that clear the control registers and the temperature-averaging accumulator. Wake-up times are modelled by a down-counter in system clock cycles. The pin passes through a two-flop synchroniser, and its low time is measured in system clock cycles against a parameter.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `state_o` reads 3 (powering up) and `ready` stays low for exactly `FULL_WAKE_CYC` cycles; then `state_o` reads 0 (normal) and `ready` goes high. State codes: 0 normal, 1 partial power-down, 2 full power-down, 3 powering up.
- R2: In normal state, a frame end (`cs_rise`) with `frame_full`=1, `wr_en`=1 and `wr_ppd`=1 moves the block to state 1 at that clock edge and pulses `avg_clear` for one cycle; the same write with `frame_full`=0 leaves the block in state 0.
- R3: In state 1, a full frame with `wr_en`=1 and `wr_ppd`=0 moves the block to state 3 at that edge, and it reaches state 0 with `ready` high exactly `PART_WAKE_CYC` cycles later; a full frame with `wr_ppd`=1 or a frame with `frame_full`=0 leaves it in state 1.
- R4: `cfg_we` is high exactly when `cs_rise`, `frame_full` and `wr_en` are all high while `ready` is high; it stays low in states 1, 2 and 3.
- R5: After a return to normal state, `res_valid` is low until a full frame has carried an accepted configuration write; it goes high at the end of the next full frame, so the frame starting after that one is the first valid one (the fourth frame counting the wake-up write). Any power-down entry or register reset clears it.
- R6: If the synchronised pin is low for 1 to `LOW_THRESH` cycles and then returns high, `reg_clear` pulses for one cycle with no `avg_clear`, `res_valid` is cleared, and the state becomes 0 (or stays 3 if it was 3).
- R7: On the (`LOW_THRESH`+1)-th consecutive synchronised low cycle of the pin, the block enters state 2 with `reg_clear` and `avg_clear` pulsing together for one cycle; it stays in state 2 until the pin returns high, then moves to state 3 and needs `FULL_WAKE_CYC` more cycles to reach state 0.
- R8: While the synchronised pin is low, `ready` and `cfg_we` are low and frames have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| pin_n | input | 1 | Asynchronous active-low reset / power-down pin |
| cs_rise | input | 1 | One-cycle pulse at the chip-select rising edge ending a frame |
| frame_full | input | 1 | Frame that is ending had all sixteen serial clocks |
| wr_en | input | 1 | Frame carries a control-register write |
| wr_ppd | input | 1 | Partial power-down bit of that write |
| state_o | output | 2 | Power state: 0 normal, 1 partial, 2 full, 3 powering up |
| ready | output | 1 | Normal state and pin high; writes accepted |
| cfg_we | output | 1 | Control-register write enable for this frame |
| res_valid | output | 1 | Frame now starting carries a valid result |
| reg_clear | output | 1 | One-cycle pulse clearing the control registers |
| avg_clear | output | 1 | One-cycle pulse clearing the temperature averaging |

## Verification
A wrong state register appears at once on `state_o` and, one cycle later at most, as a missing or extra `reg_clear`/`avg_clear` pulse, which the scoreboard matches event by event in order. A wake-up counter that is off by one moves the rise of `ready` by a cycle, so `ready` is sampled one cycle before and at the exact expiry. A low-time counter that misjudges the threshold turns a register reset into a full power-down, which shows as state 2 and a combined clear pulse within two cycles of the boundary pulse width. A result-tracking flag that is set too early or too late raises `res_valid` one frame off from the fourth frame.

// File: rtl/pwr_pkg.sv
// Shared types of the power-mode controller.
package pwr_pkg;

    // Power state codes; the encoding is visible on the state_o port.
    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_PART   = 2'd1,
        PM_FULL   = 2'd2,
        PM_WAKE   = 2'd3
    } pm_state_e;

endpackage

// File: rtl/pwr_pin_filter.sv
// Synchronises the asynchronous active-low pin and classifies each low
// period by its length in system clock cycles.
// Assumes: the pin may change at any time; LOW_THRESH >= 1.
// A low period of 1..LOW_THRESH cycles yields short_rst on release; the
// (LOW_THRESH+1)-th low cycle yields long_start, and the release after a
// long period yields long_end.
module pwr_pin_filter #(
    parameter int LOW_THRESH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_ok,
    output logic short_rst,
    output logic long_start,
    output logic long_end
);

    localparam int LW = $clog2(LOW_THRESH + 2);
    localparam logic [LW-1:0] THR = LW'(LOW_THRESH);
    localparam logic [LW-1:0] SAT = LW'(LOW_THRESH + 1);

    logic meta_q, sync_q;
    logic [LW-1:0] low_cnt_q;

    // Two-flop synchroniser; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_n;
            sync_q <= meta_q;
        end
    end

    // Count synchronised low cycles, saturating one past the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt_q <= '0;
        else if (sync_q)
            low_cnt_q <= '0;
        else if (low_cnt_q != SAT)
            low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign pin_ok     = sync_q;
    assign short_rst  = sync_q && (low_cnt_q != '0) && (low_cnt_q <= THR);
    assign long_start = !sync_q && (low_cnt_q == THR);
    assign long_end   = sync_q && (low_cnt_q == SAT);

endmodule

// File: rtl/pwr_wake_timer.sv
// Down-counter timing a power-up. Loaded with a cycle count on entry to
// the powering-up state; expired is high in the last counted cycle.
// Assumes: load values are >= 1; the counter rests at zero when idle.
module pwr_wake_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == W'(1));

    // R3
    timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0);

endmodule

// File: rtl/pwr_result_track.sv
// Tracks whether the frame now starting returns a valid conversion.
// A full frame with an accepted configuration write arms the tracker;
// the next full frame starts a valid conversion, whose result appears in
// the frame after it. Assumes frame_end only pulses in normal state.
module pwr_result_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic frame_end,
    input  logic cfg_acc,
    output logic res_valid
);

    logic cfg_ok_q, res_q;

    // Two-stage pipeline of configuration and conversion validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ok_q <= 1'b0;
            res_q    <= 1'b0;
        end else if (clear) begin
            cfg_ok_q <= 1'b0;
            res_q    <= 1'b0;
        end else if (frame_end) begin
            res_q <= cfg_ok_q;
            if (cfg_acc)
                cfg_ok_q <= 1'b1;
        end
    end

    assign res_valid = res_q;

    // R5
    res_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_q |-> cfg_ok_q);

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power-mode and reset controller. Tracks normal, partial power-down,
// full power-down and powering-up states from serial frame ends and an
// asynchronous reset/power-down pin; drives the write gate, result-valid
// flag and one-cycle clear pulses.
// Assumes: cs_rise is a one-cycle pulse already in the clk domain and the
// frame qualifiers are valid with it; wake times are >= 2 cycles.
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int LOW_THRESH    = 10,
    parameter int FULL_WAKE_CYC = 50000,
    parameter int PART_WAKE_CYC = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_n,
    input  logic       cs_rise,
    input  logic       frame_full,
    input  logic       wr_en,
    input  logic       wr_ppd,
    output logic [1:0] state_o,
    output logic       ready,
    output logic       cfg_we,
    output logic       res_valid,
    output logic       reg_clear,
    output logic       avg_clear
);

    localparam int MAX_WAKE = (FULL_WAKE_CYC > PART_WAKE_CYC) ? FULL_WAKE_CYC : PART_WAKE_CYC;
    localparam int CNT_W    = $clog2(MAX_WAKE + 1);

    pm_state_e        state_q, state_d;
    logic             rc_q, rc_d, ac_q, ac_d;
    logic             pin_ok, short_rst, long_start, long_end;
    logic             wake_load, wake_done;
    logic [CNT_W-1:0] wake_val;
    logic             frame_end, write_acc;

    pwr_pin_filter #(.LOW_THRESH(LOW_THRESH)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (pin_n),
        .pin_ok     (pin_ok),
        .short_rst  (short_rst),
        .long_start (long_start),
        .long_end   (long_end)
    );

    pwr_wake_timer #(.W(CNT_W), .RST_VAL(FULL_WAKE_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake_load),
        .load_val (wake_val),
        .expired  (wake_done)
    );

    assign frame_end = cs_rise && frame_full;
    assign write_acc = frame_end && wr_en;
    assign ready     = (state_q == PM_NORMAL) && pin_ok;
    assign cfg_we    = ready && write_acc;

    // Next-state selection: pin events take priority over frame events.
    always_comb begin
        state_d   = state_q;
        rc_d      = 1'b0;
        ac_d      = 1'b0;
        wake_load = 1'b0;
        wake_val  = CNT_W'(PART_WAKE_CYC);
        if (long_start && state_q != PM_FULL) begin
            state_d = PM_FULL;
            rc_d    = 1'b1;
            ac_d    = 1'b1;
        end else if (long_end && state_q == PM_FULL) begin
            state_d   = PM_WAKE;
            wake_load = 1'b1;
            wake_val  = CNT_W'(FULL_WAKE_CYC);
        end else if (short_rst) begin
            rc_d = 1'b1;
            if (state_q != PM_WAKE)
                state_d = PM_NORMAL;
        end else begin
            unique case (state_q)
                PM_NORMAL: if (cfg_we && wr_ppd) begin
                    state_d = PM_PART;
                    ac_d    = 1'b1;
                end
                PM_PART: if (pin_ok && write_acc && !wr_ppd) begin
                    state_d   = PM_WAKE;
                    wake_load = 1'b1;
                end
                PM_WAKE: if (wake_done)
                    state_d = PM_NORMAL;
                default: ;
            endcase
        end
    end

    // State and clear-pulse registers; power-on starts a full wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_WAKE;
            rc_q    <= 1'b0;
            ac_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rc_q    <= rc_d;
            ac_q    <= ac_d;
        end
    end

    pwr_result_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rc_d || ac_d),
        .frame_end (ready && frame_end),
        .cfg_acc   (cfg_we),
        .res_valid (res_valid)
    );

    assign state_o   = state_q;
    assign reg_clear = rc_q;
    assign avg_clear = ac_q;

    // R2
    avg_in_powerdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avg_clear |-> (state_q == PM_PART || state_q == PM_FULL));

    // R5
    res_only_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> state_q == PM_NORMAL);

    // R7
    full_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PM_FULL |=> (state_q == PM_FULL || state_q == PM_WAKE));

    // R3
    normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_NORMAL && $past(state_q) != PM_NORMAL)
            |-> ($past(state_q) == PM_WAKE || reg_clear));

    // R6
    reset_clears_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clear |-> !res_valid);

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
// Scoreboard bench: stimulus tasks push expected state/pulse events into a
// queue; a monitor pops and compares them as the design produces them.
module tb_pwr_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LT = 8;
    localparam int FW = 40;
    localparam int PW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1;
    logic cs_rise = 1'b0, frame_full = 1'b0, wr_en = 1'b0, wr_ppd = 1'b0;
    logic [1:0] state_o;
    logic ready, cfg_we, res_valid, reg_clear, avg_clear;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic [1:0] prev_st;
    logic [3:0] exp_q[$];
    string tag_q[$];

    pwr_mode_ctrl #(.LOW_THRESH(LT), .FULL_WAKE_CYC(FW), .PART_WAKE_CYC(PW)) dut (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .cs_rise(cs_rise),
        .frame_full(frame_full), .wr_en(wr_en), .wr_ppd(wr_ppd),
        .state_o(state_o), .ready(ready), .cfg_we(cfg_we),
        .res_valid(res_valid), .reg_clear(reg_clear), .avg_clear(avg_clear)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(string tag, logic [1:0] st, bit rc, bit ac);
        exp_q.push_back({st, rc, ac});
        tag_q.push_back(tag);
    endtask

    // One frame end: drive qualifiers for one cycle, sample cfg_we mid-cycle.
    task automatic frame(bit full, bit we, bit ppd, output logic we_seen);
        @(negedge clk);
        cs_rise = 1'b1; frame_full = full; wr_en = we; wr_ppd = ppd;
        #(CLK_PERIOD/4);
        we_seen = cfg_we;
        @(negedge clk);
        cs_rise = 1'b0; frame_full = 1'b0; wr_en = 1'b0; wr_ppd = 1'b0;
    endtask

    // Monitor: every state change or clear pulse must match the queue head.
    always @(negedge clk) begin
        logic [3:0] e;
        string t;
        if (mon_on && !done) begin
            if (state_o != prev_st || reg_clear || avg_clear) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected event R2/R3/R6/R7: actual %0h expected none",
                             {state_o, reg_clear, avg_clear});
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e != {state_o, reg_clear, avg_clear}) begin
                        n_fail++;
                        $display("FAIL %s event: actual %0h expected %0h",
                                 t, {state_o, reg_clear, avg_clear}, e);
                    end
                end
            end
            prev_st = state_o;
        end
    end

    initial begin
        logic w;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset state", state_o, 3);
        check("R1 reset ready", ready, 0);
        check("R1 reset reg_clear", reg_clear, 0);
        check("R1 reset avg_clear", avg_clear, 0);
        check("R1 reset res_valid", res_valid, 0);
        expect_ev("R1", 2'd0, 1'b0, 1'b0);
        rst_n = 1'b1; prev_st = 2'd3; mon_on = 1'b1;
        repeat (FW-1) @(negedge clk);
        check("R1 ready before expiry", ready, 0);
        @(negedge clk);
        check("R1 ready at expiry", ready, 1);
        check("R1 normal state", state_o, 0);

        // R4/R5: configuration write in normal state
        frame(1, 1, 0, w);
        check("R4 cfg_we on full write", w, 1);
        check("R5 res_valid after config frame", res_valid, 0);
        // R2: short frame with PPD=1 does not enter partial
        frame(0, 1, 1, w);
        check("R4 cfg_we on short frame", w, 0);
        check("R2 short frame keeps normal", state_o, 0);
        frame(1, 0, 0, w);
        check("R5 res_valid after conversion frame", res_valid, 1);

        // R2: enter partial power-down
        expect_ev("R2", 2'd1, 1'b0, 1'b1);
        frame(1, 1, 1, w);
        check("R4 cfg_we on PPD write", w, 1);
        check("R2 partial state", state_o, 1);
        check("R2 ready low in partial", ready, 0);
        check("R5 res_valid cleared in partial", res_valid, 0);

        // R3: frames that must not wake
        frame(1, 1, 1, w);
        check("R4 cfg_we gated in partial", w, 0);
        check("R3 PPD=1 keeps partial", state_o, 1);
        frame(0, 1, 0, w);
        check("R3 short frame keeps partial", state_o, 1);

        // R3: wake from partial
        expect_ev("R3", 2'd3, 1'b0, 1'b0);
        expect_ev("R3", 2'd0, 1'b0, 1'b0);
        frame(1, 1, 0, w);
        check("R3 powering up", state_o, 3);
        repeat (PW-1) @(negedge clk);
        check("R3 ready before expiry", ready, 0);
        @(negedge clk);
        check("R3 ready at expiry", ready, 1);

        // R5: fourth frame is the first valid one
        frame(1, 1, 0, w);
        check("R5 res_valid after second frame", res_valid, 0);
        frame(1, 0, 0, w);
        check("R5 res_valid for fourth frame", res_valid, 1);

        // R6/R8: boundary short pulse (LT cycles) with a frame during it
        expect_ev("R6", 2'd0, 1'b1, 1'b0);
        @(negedge clk); pin_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 ready low while pin low", ready, 0);
        frame(1, 1, 1, w);
        check("R8 cfg_we gated while pin low", w, 0);
        check("R8 frame ignored while pin low", state_o, 0);
        repeat (3) @(negedge clk); pin_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 res_valid cleared by reset", res_valid, 0);
        check("R6 ready after reset", ready, 1);
        check("R6 normal after reset", state_o, 0);

        // R6: short pulse from partial returns to normal
        expect_ev("R2", 2'd1, 1'b0, 1'b1);
        frame(1, 1, 1, w);
        expect_ev("R6", 2'd0, 1'b1, 1'b0);
        @(negedge clk); pin_n = 1'b0;
        repeat (3) @(negedge clk); pin_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R6 partial reset to normal", state_o, 0);

        // R7: boundary long pulse (LT+1 cycles)
        expect_ev("R7", 2'd2, 1'b1, 1'b1);
        expect_ev("R7", 2'd3, 1'b0, 1'b0);
        expect_ev("R7", 2'd0, 1'b0, 1'b0);
        @(negedge clk); pin_n = 1'b0;
        repeat (LT+1) @(negedge clk); pin_n = 1'b1;
        repeat (FW+2) @(negedge clk);
        check("R7 ready before full wake expiry", ready, 0);
        @(negedge clk);
        check("R7 ready at full wake expiry", ready, 1);

        // R7/R8: long hold stays in full power-down
        expect_ev("R7", 2'd2, 1'b1, 1'b1);
        expect_ev("R7", 2'd3, 1'b0, 1'b0);
        expect_ev("R7", 2'd0, 1'b0, 1'b0);
        @(negedge clk); pin_n = 1'b0;
        repeat (14) @(negedge clk);
        check("R7 full state while held", state_o, 2);
        frame(1, 1, 0, w);
        check("R8 cfg_we gated in full", w, 0);
        repeat (4) @(negedge clk); pin_n = 1'b1;
        repeat (FW+6) @(negedge clk);
        check("R7 normal after full wake", state_o, 0);
        check("R5 res_valid low after full wake", res_valid, 0);

        repeat (5) @(negedge clk);
        check("R7 all expected events seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule